// File: doc/BRIEF.md
# Page History Bit Updater

This block keeps the referenced and changed history bits of memory pages up to date. It sits next to a translation buffer and a page table in memory. The load/store path presents one access at a time. Each access carries its kind, the translation hit flag and entry index, the referenced and changed bits held in that entry, a protection-permit flag, a committed flag and the memory address of the matching page table word.

When neither bit needs to change, the block completes the access in one cycle with no traffic. Otherwise it reads the page table word over a request/acknowledge memory port, ORs in the missing bit or bits, and writes the word back. It then rewrites the translation entry with the new bit values. Changed is recorded lazily. Only a committed store that protection allows, and whose cached changed bit is still clear, triggers it. Cache-touch accesses can mark a page referenced but never changed.

Top module: `pg_hist_upd`

## Requirements
- R1: During and right after reset, reqReady is 1, busy is 0, and memReq and tlbWrEn are 0.
- R2: A hit with kind STORE (encoding 1), reqPermit=1, reqCommit=1 and reqChgBit=0 reads the page table word, writes it back with bit CHG_POS (default 7) set, and then writes entry reqTlbIdx with tlbWrChg=1.
- R3: A hit store whose reqChgBit is already 1 and whose reqRefBit is 1 produces no memory request and no translation write.
- R4: A store with reqPermit=0 or reqCommit=0 never sets the changed bit, in memory or in the translation entry.
- R5: Touch kinds (load-touch 3, store-touch 4) never set the changed bit. They set the referenced bit when it is clear.
- R6: Any hit with reqRefBit=0 sets bit REF_POS (default 8) in memory and tlbWrRef=1. This holds for every kind (load 0, store 1, fetch 2, touches), including uncommitted or non-permitted accesses.
- R7: The write request starts only after the read acknowledge. The translation write follows the write acknowledge, so memory is updated before the entry.
- R8: The written word equals the word read, with only the needed history bits added. All other bits are preserved.
- R9: After an updating access is accepted, reqReady stays 0 until the update ends. An access presented meanwhile is held and later accepted, not dropped.
- R10: An access with reqTlbHit=0 causes no memory or translation traffic.
- R11: An access needing no bit change is accepted with reqReady still 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access present |
| reqReady | output | 1 | Access accepted on this edge when valid |
| reqKind | input | 3 | 0 load, 1 store, 2 fetch, 3 load-touch, 4 store-touch |
| reqTlbHit | input | 1 | Translation hit |
| reqTlbIdx | input | IDX_W | Index of the hit entry |
| reqRefBit | input | 1 | Referenced bit held in the entry |
| reqChgBit | input | 1 | Changed bit held in the entry |
| reqPermit | input | 1 | Protection allows the access |
| reqCommit | input | 1 | Access is on the committed path |
| reqPteAddr | input | ADDR_W | Address of the page table word |
| busy | output | 1 | Update in progress |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | DATA_W | Memory read data |
| tlbWrEn | output | 1 | Translation entry write strobe |
| tlbWrIdx | output | IDX_W | Entry to rewrite |
| tlbWrRef | output | 1 | New referenced bit |
| tlbWrChg | output | 1 | New changed bit |

## Verification
The assertions check on every cycle that reqReady drops after an updating acceptance and stays up after a trivial one. They check that the write request only follows a read acknowledge, that the entry write only follows a write acknowledge, and that a touch never raises the changed bit. The bench scenarios show the cases the assertions cannot. These are the actual memory word after each update, with untouched bits preserved. They also cover suppression of the changed bit for uncommitted, non-permitted, miss and already-set cases, and a held access being served after a busy period.

// File: rtl/pg_hist_pkg.sv
package pg_hist_pkg;
  typedef enum logic [2:0] {
    ACC_LOAD     = 3'd0,
    ACC_STORE    = 3'd1,
    ACC_IFETCH   = 3'd2,
    ACC_TOUCH_LD = 3'd3,
    ACC_TOUCH_ST = 3'd4
  } accKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_TLB,
    ST_DONE
  } updState_e;

  typedef struct packed {
    logic capReq;
    logic capRd;
  } dpStrobe_t;
endpackage

// File: rtl/pg_hist_dp.sv
module pg_hist_dp
  import pg_hist_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6,
  parameter int REF_POS = 8,
  parameter int CHG_POS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [2:0]        reqKind,
  input  logic              reqTlbHit,
  input  logic [IDX_W-1:0]  reqTlbIdx,
  input  logic              reqRefBit,
  input  logic              reqChgBit,
  input  logic              reqPermit,
  input  logic              reqCommit,
  input  logic [ADDR_W-1:0] reqPteAddr,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              tlbWrEn,
  output logic              needAny,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [IDX_W-1:0]  tlbWrIdx,
  output logic              tlbWrRef,
  output logic              tlbWrChg
);
  localparam logic [DATA_W-1:0] REF_MASK = DATA_W'(1) << REF_POS;
  localparam logic [DATA_W-1:0] CHG_MASK = DATA_W'(1) << CHG_POS;

  accKind_e kind;
  logic     isStore;
  logic     isTouch;
  logic     needR;
  logic     needC;

  logic [IDX_W-1:0]  savIdx;
  logic [ADDR_W-1:0] savAddr;
  logic              savRef;
  logic              savChg;
  logic              setR;
  logic              setC;
  logic              savTouch;
  logic [DATA_W-1:0] rdWord;

  assign kind    = accKind_e'(reqKind);
  assign isStore = (kind == ACC_STORE);
  assign isTouch = (kind == ACC_TOUCH_LD) || (kind == ACC_TOUCH_ST);
  // referenced is recorded for any hit, even speculative or refused ones
  assign needR   = reqTlbHit && !reqRefBit;
  // changed is recorded lazily: committed, permitted store with clear copy
  assign needC   = reqTlbHit && isStore && reqPermit && reqCommit && !reqChgBit;
  assign needAny = needR || needC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savIdx   <= '0;
      savAddr  <= '0;
      savRef   <= 1'b0;
      savChg   <= 1'b0;
      setR     <= 1'b0;
      setC     <= 1'b0;
      savTouch <= 1'b0;
    end else if (strobe.capReq) begin
      savIdx   <= reqTlbIdx;
      savAddr  <= reqPteAddr;
      savRef   <= reqRefBit;
      savChg   <= reqChgBit;
      setR     <= needR;
      setC     <= needC;
      savTouch <= isTouch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWord <= '0;
    end else if (strobe.capRd) begin
      rdWord <= memRdata;
    end
  end

  always_comb begin
    memWdata = rdWord;
    if (setR) memWdata = memWdata | REF_MASK;
    if (setC) memWdata = memWdata | CHG_MASK;
  end

  assign memAddr  = savAddr;
  assign tlbWrIdx = savIdx;
  assign tlbWrRef = savRef | setR;
  assign tlbWrChg = savChg | setC;

  // R5
  touch_no_chg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tlbWrEn && savTouch) |-> (tlbWrChg == savChg));

endmodule

// File: rtl/pg_hist_ctrl.sv
module pg_hist_ctrl
  import pg_hist_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      needAny,
  input  logic      memAck,
  output logic      reqReady,
  output logic      busy,
  output logic      memReq,
  output logic      memWe,
  output logic      tlbWrEn,
  output dpStrobe_t strobe
);
  updState_e state;
  updState_e stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (reqValid && needAny) stateNxt = ST_RD;
      ST_RD:   if (memAck) stateNxt = ST_WR;
      ST_WR:   if (memAck) stateNxt = ST_TLB;
      ST_TLB:  stateNxt = ST_DONE;
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady      = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign memReq        = (state == ST_RD) || (state == ST_WR);
  assign memWe         = (state == ST_WR);
  assign tlbWrEn       = (state == ST_TLB);
  assign strobe.capReq = (state == ST_IDLE) && reqValid;
  assign strobe.capRd  = (state == ST_RD) && memAck;

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && needAny) |=> (!reqReady && memReq && !memWe));

  // R11
  quick_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !needAny) |=> (reqReady && !memReq && !tlbWrEn));

  // R7
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !$past(memWe)) |-> $past(memAck && memReq));

  // R7
  tlb_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    tlbWrEn |-> $past(memAck && memReq && memWe));

endmodule

// File: rtl/pg_hist_upd.sv
module pg_hist_upd
  import pg_hist_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6,
  parameter int REF_POS = 8,
  parameter int CHG_POS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqKind,
  input  logic              reqTlbHit,
  input  logic [IDX_W-1:0]  reqTlbIdx,
  input  logic              reqRefBit,
  input  logic              reqChgBit,
  input  logic              reqPermit,
  input  logic              reqCommit,
  input  logic [ADDR_W-1:0] reqPteAddr,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              tlbWrEn,
  output logic [IDX_W-1:0]  tlbWrIdx,
  output logic              tlbWrRef,
  output logic              tlbWrChg
);
  dpStrobe_t strobe;
  logic      needAny;

  pg_hist_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .needAny  (needAny),
    .memAck   (memAck),
    .reqReady (reqReady),
    .busy     (busy),
    .memReq   (memReq),
    .memWe    (memWe),
    .tlbWrEn  (tlbWrEn),
    .strobe   (strobe)
  );

  pg_hist_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .REF_POS(REF_POS),
    .CHG_POS(CHG_POS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqKind    (reqKind),
    .reqTlbHit  (reqTlbHit),
    .reqTlbIdx  (reqTlbIdx),
    .reqRefBit  (reqRefBit),
    .reqChgBit  (reqChgBit),
    .reqPermit  (reqPermit),
    .reqCommit  (reqCommit),
    .reqPteAddr (reqPteAddr),
    .memRdata   (memRdata),
    .tlbWrEn    (tlbWrEn),
    .needAny    (needAny),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .tlbWrIdx   (tlbWrIdx),
    .tlbWrRef   (tlbWrRef),
    .tlbWrChg   (tlbWrChg)
  );

endmodule

// File: tb/pg_hist_upd_tb_top.sv
module pg_hist_upd_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;
  localparam logic [DATA_W-1:0] RMASK = 32'h0000_0100;
  localparam logic [DATA_W-1:0] CMASK = 32'h0000_0080;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic [2:0] reqKind = 0;
  logic reqTlbHit = 0;
  logic [IDX_W-1:0] reqTlbIdx = 0;
  logic reqRefBit = 0, reqChgBit = 0, reqPermit = 0, reqCommit = 0;
  logic [ADDR_W-1:0] reqPteAddr = 0;
  logic reqReady, busy, memReq, memWe, tlbWrEn, tlbWrRef, tlbWrChg;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic memAck = 0;
  logic [DATA_W-1:0] memRdata = 0;
  logic [IDX_W-1:0] tlbWrIdx;

  always #5 clk = ~clk;

  pg_hist_upd dut_i (.*);

  typedef struct {
    logic [IDX_W-1:0]  idx;
    logic              ref_;
    logic              chg;
    logic [DATA_W-1:0] word;
    string             tag;
  } expItem_t;

  expItem_t          expQ[$];
  logic [DATA_W-1:0] mem[16];
  logic [DATA_W-1:0] shadow[16];
  int checks = 0, failures = 0, memWrCnt = 0, tlbCnt = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: acknowledges after two idle cycles
  initial begin
    int dly = 0;
    for (int i = 0; i < 16; i++) begin
      mem[i]    = (32'h5A3C_0E7F + i * 32'h0101_0101) & ~(RMASK | CMASK);
      shadow[i] = mem[i];
    end
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 0;
        dly = 0;
      end else if (rstN && memReq) begin
        if (dly == 2) begin
          memAck   = 1;
          memRdata = mem[memAddr[5:2]];
          if (memWe) begin
            mem[memAddr[5:2]] = memWdata;
            memWrCnt++;
          end
        end else dly++;
      end
    end
  end

  // monitor: compare entry rewrites and memory against expectations
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && tlbWrEn) begin
        expItem_t e;
        tlbCnt++;
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected entry write", 64'(tlbWrIdx), 64'h0);
        end else begin
          e = expQ.pop_front();
          check(tlbWrIdx == e.idx, {e.tag, " idx"}, 64'(tlbWrIdx), 64'(e.idx));
          check(tlbWrRef == e.ref_, {e.tag, " ref"}, 64'(tlbWrRef), 64'(e.ref_));
          check(tlbWrChg == e.chg, {e.tag, " chg"}, 64'(tlbWrChg), 64'(e.chg));
          // R7 R8: memory already holds the updated word
          check(mem[e.idx[3:0]] == e.word, {e.tag, " R7 R8 word"}, 64'(mem[e.idx[3:0]]), 64'(e.word));
        end
      end
    end
  end

  task automatic send(input logic [2:0] kind, input bit hit, input int idx, input bit rb,
                      input bit cb, input bit perm, input bit comm, input string tag);
    bit nR, nC;
    int wr0, tl0;
    nR = hit && !rb;
    nC = hit && kind == 3'd1 && perm && comm && !cb;
    if (nR || nC) begin
      expItem_t e;
      if (nR) shadow[idx] = shadow[idx] | RMASK;
      if (nC) shadow[idx] = shadow[idx] | CMASK;
      e.idx = IDX_W'(idx); e.ref_ = rb | nR; e.chg = cb | nC; e.word = shadow[idx]; e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge clk);
    reqValid = 1; reqKind = kind; reqTlbHit = hit; reqTlbIdx = IDX_W'(idx);
    reqRefBit = rb; reqChgBit = cb; reqPermit = perm; reqCommit = comm;
    reqPteAddr = ADDR_W'(idx * 4);
    while (!reqReady) @(negedge clk);
    wr0 = memWrCnt; tl0 = tlbCnt;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    // R9 / R11: ready follows the need for an update
    check(reqReady == !(nR || nC), {tag, " R9 R11 ready"}, 64'(reqReady), 64'(!(nR || nC)));
    if (!(nR || nC)) begin
      repeat (6) @(negedge clk);
      check(memWrCnt == wr0 && tlbCnt == tl0, {tag, " no traffic"}, 64'(memWrCnt - wr0), 64'h0);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(reqReady && !busy && !memReq && !tlbWrEn, "R1 in reset", {reqReady, busy, memReq, tlbWrEn}, 4'b1000);
    rstN = 1;
    @(negedge clk);
    check(reqReady && !busy && !memReq && !tlbWrEn, "R1 after reset", {reqReady, busy, memReq, tlbWrEn}, 4'b1000);

    send(3'd1, 1, 5, 1, 0, 1, 1, "R2 store sets C");
    send(3'd1, 1, 5, 1, 1, 1, 1, "R3 store C already set");
    send(3'd0, 1, 2, 0, 0, 1, 1, "R6 load sets R");
    send(3'd1, 1, 3, 0, 0, 1, 0, "R4 R6 speculative store");
    send(3'd1, 1, 4, 1, 0, 0, 1, "R4 refused store");
    send(3'd4, 1, 6, 0, 0, 1, 1, "R5 store-touch");
    send(3'd3, 1, 7, 1, 0, 1, 1, "R5 load-touch R set");
    send(3'd1, 0, 8, 0, 0, 1, 1, "R10 miss");
    send(3'd1, 1, 9, 0, 0, 1, 1, "R2 R6 store sets both");
    send(3'd2, 1, 10, 0, 0, 1, 0, "R6 unused fetch");
    // R9: second access held while the first update runs
    send(3'd1, 1, 11, 1, 0, 1, 1, "R9 first");
    send(3'd1, 1, 12, 1, 0, 1, 1, "R9 held second");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R9 all updates served", 64'(expQ.size()), 64'h0);
    check(tlbCnt == 8, "R2 entry write count", 64'(tlbCnt), 64'd8);
    check(memWrCnt == 8, "R7 memory write count", 64'(memWrCnt), 64'd8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule